// File: doc/BRIEF.md
# Host-to-DMA Write FIFO Bridge

The bridge sits between a host processor's register bus and one channel of a DMA engine on a second bus. The host sets a start flag, programs a transfer length, and then writes 16-bit words into a small FIFO through a data register. Once the FIFO holds a nonzero multiple of four words, and the DMA channel is set to the request-driven mode and is globally enabled, the bridge raises a DMA request. It then presents the words in order, together with a destination address, one word for each acknowledge.

Each word that moves advances the destination address by two bytes and decrements the channel transfer count and the host length. When the host length reaches zero, the bridge drops the host start flag. When the channel count reaches zero, it sets the channel's transfer-end flag. If the channel count and the host length differ when a burst begins, a sticky error output is raised. The FIFO depth is a parameter and must be a multiple of four.

Top module: `dreq_fifo_bridge`

## Requirements
- R1: A write to the length register (select 1) stores the written value with bits 1:0 forced to zero.
- R2: A write to the data register (select 2) while the start flag is clear leaves the FIFO unchanged and pulses `anomaly` high for exactly the next cycle.
- R3: `dmaReq` is raised only when the FIFO fill is a nonzero multiple of four, `chanMode` equals 1 and `dmaGlobalEn` is high. If the channel count is zero, it stays low.
- R4: Each cycle with `dmaReq` and `dmaAck` both high moves one word: `dmaWrAddr` rises by 2, `chanCount` falls by 1, and `hostLen` falls by 1 unless it is already zero.
- R5: `fifoFull` (control bit 7) is high exactly when the fill equals the depth. A burst ends once every stored word is moved or the channel count reaches zero, and the FIFO is then emptied.
- R6: The pop that brings `hostLen` from 1 to 0 clears the start flag.
- R7: The pop that brings `chanCount` from 1 to 0 sets `chanEnd`. Any words still stored are then discarded. A `cfgLoad` pulse loads the count and address and clears `chanEnd`.
- R8: A control write (select 0) changes only the start flag (bit 0) and the ROM-visible flag (bit 1). Reading select 0 returns those bits with `fifoFull` in bit 7 and zeros elsewhere.
- R9: If `chanCount` differs from `hostLen` when a burst begins, `lenMismatchErr` is set and stays set until reset.
- R10: Data writes are ignored while the FIFO is full or a burst is starting or in progress.
- R11: Words appear on `dmaWrData` in the order the host wrote them.
- R12: After reset, every flag, counter, address and the FIFO fill are zero, and `dmaReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostSel | input | 2 | Register select: 0 control, 1 length, 2 data |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Read data of the selected register (data register reads 0) |
| startFlag | output | 1 | Host start flag |
| romVisible | output | 1 | ROM-visible flag |
| fifoFull | output | 1 | FIFO full status |
| hostLen | output | 16 | Remaining host length in words |
| anomaly | output | 1 | One-cycle pulse on a data write made without the start flag |
| chanMode | input | 2 | DMA channel mode field; 1 selects request-driven transfer |
| dmaGlobalEn | input | 1 | Global DMA enable |
| cfgLoad | input | 1 | Load channel count and destination address |
| cfgCount | input | 24 | Channel transfer count to load |
| cfgDstAddr | input | 32 | Destination address to load |
| dmaReq | output | 1 | DMA request |
| dmaAck | input | 1 | DMA acknowledge; pops one word while `dmaReq` is high |
| dmaWrAddr | output | 32 | Destination address of the current word |
| dmaWrData | output | 16 | Current word |
| chanCount | output | 24 | Channel transfer count |
| chanEnd | output | 1 | Channel transfer-end flag |
| lenMismatchErr | output | 1 | Sticky count/length mismatch error |

## Verification
The bench builds the bridge with a depth of eight rather than the default four. This separates two conditions that coincide at depth four: reaching a group boundary and becoming full. With global enable held low, the FIFO can fill to a non-aligned level of five and be shown to stay quiet, then fill to eight to exercise the full flag and a dropped ninth write. A burst of eight words then drains across two groups. Acknowledge stalls, a wrong mode value, and a channel count that runs out partway through a burst are all compared on every cycle against a queue-based model.

// File: rtl/dreq_bridge_pkg.sv
package dreq_bridge_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } hostSel_e;

  localparam int CTRL_START_BIT  = 0;
  localparam int CTRL_ROMVIS_BIT = 1;
  localparam int CTRL_FULL_BIT   = 7;
  localparam int GROUP_WORDS     = 4;
  localparam logic [1:0] MODE_REQ_DRIVEN = 2'd1;

  typedef struct packed {
    logic ctrlWrite;
    logic lenWrite;
    logic pushWord;
    logic popWord;
    logic clearFill;
    logic cfgLoad;
    logic markMismatch;
    logic markAnomaly;
  } strobe_t;

endpackage

// File: rtl/dreq_control.sv
module dreq_control
  import dreq_bridge_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic [1:0]       hostSel,
  input  logic [1:0]       chanMode,
  input  logic             dmaGlobalEn,
  input  logic             dmaAck,
  input  logic             cfgLoad,
  input  logic [PTR_W-1:0] fillCnt,
  input  logic [PTR_W-1:0] rdIdx,
  input  logic             startFlag,
  input  logic             fifoFull,
  input  logic             chanCountZero,
  input  logic             countLenDiffer,
  output strobe_t          stb,
  output logic             dmaReq
);

  typedef enum logic {ST_IDLE, ST_DRAIN} state_e;
  state_e state, stateNext;

  logic groupReady, wordsLeft, dataWrite;

  assign groupReady = (fillCnt != '0) && (fillCnt[1:0] == 2'b00) &&
                      (chanMode == MODE_REQ_DRIVEN) && dmaGlobalEn;
  assign wordsLeft  = (rdIdx != fillCnt);
  assign dataWrite  = hostWrEn && (hostSel == SEL_DATA);
  assign dmaReq     = (state == ST_DRAIN) && wordsLeft && !chanCountZero;

  always_comb begin
    stb              = '0;
    stb.ctrlWrite    = hostWrEn && (hostSel == SEL_CTRL);
    stb.lenWrite     = hostWrEn && (hostSel == SEL_LEN);
    stb.markAnomaly  = dataWrite && !startFlag;
    stb.pushWord     = dataWrite && startFlag && !fifoFull &&
                       (state == ST_IDLE) && !groupReady;
    stb.popWord      = dmaReq && dmaAck;
    stb.clearFill    = (state == ST_DRAIN) && !dmaReq;
    stb.cfgLoad      = cfgLoad;
    stb.markMismatch = (state == ST_IDLE) && groupReady && countLenDiffer;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (groupReady) stateNext = ST_DRAIN;
      ST_DRAIN: if (!dmaReq)    stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_DRAIN_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN) |-> (fillCnt != '0 && fillCnt[1:0] == 2'b00))
    else $error("burst running on unaligned fill"); // R3

  AST_NO_WRITE_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN) |=> $stable(fillCnt) || (fillCnt == '0))
    else $error("fill changed during burst"); // R10

endmodule

// File: rtl/dreq_datapath.sv
module dreq_datapath
  import dreq_bridge_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int ADDR_STEP = 2,
  parameter int PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  output logic [DATA_W-1:0] hostRdData,
  output logic [PTR_W-1:0]  fillCnt,
  output logic [PTR_W-1:0]  rdIdx,
  output logic              startFlag,
  output logic              romVisible,
  output logic              fifoFull,
  output logic [LEN_W-1:0]  hostLen,
  output logic              anomaly,
  output logic [ADDR_W-1:0] dmaWrAddr,
  output logic [DATA_W-1:0] dmaWrData,
  output logic [CNT_W-1:0]  chanCount,
  output logic              chanCountZero,
  output logic              countLenDiffer,
  output logic              chanEnd,
  output logic              lenMismatchErr
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0]  FULL_LEVEL = PTR_W'(DEPTH);
  localparam logic [LEN_W-1:0]  LEN_MASK   = ~LEN_W'(GROUP_WORDS - 1);
  localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(ADDR_STEP);

  logic [DATA_W-1:0] entryQ [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk) begin
      if (stb.pushWord && fillCnt == PTR_W'(e)) word <= hostWrData;
    end
    assign entryQ[e] = word;
  end

  assign fifoFull       = (fillCnt == FULL_LEVEL);
  assign dmaWrData      = entryQ[rdIdx[IDX_W-1:0]];
  assign chanCountZero  = (chanCount == '0);
  assign countLenDiffer = (chanCount != CNT_W'(hostLen));

  // fill and read pointers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
      rdIdx   <= '0;
    end else if (stb.clearFill) begin
      fillCnt <= '0;
      rdIdx   <= '0;
    end else begin
      if (stb.pushWord) fillCnt <= fillCnt + 1'b1;
      if (stb.popWord)  rdIdx   <= rdIdx + 1'b1;
    end
  end

  // host-side registers; host writes win over hardware updates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startFlag  <= 1'b0;
      romVisible <= 1'b0;
      hostLen    <= '0;
      anomaly    <= 1'b0;
    end else begin
      anomaly <= stb.markAnomaly;
      if (stb.ctrlWrite) begin
        startFlag  <= hostWrData[CTRL_START_BIT];
        romVisible <= hostWrData[CTRL_ROMVIS_BIT];
      end else if (stb.popWord && hostLen == LEN_W'(1)) begin
        startFlag  <= 1'b0;
      end
      if (stb.lenWrite)                       hostLen <= hostWrData[LEN_W-1:0] & LEN_MASK;
      else if (stb.popWord && hostLen != '0)  hostLen <= hostLen - 1'b1;
    end
  end

  // channel-side registers; a configuration load wins over a pop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanCount      <= '0;
      dmaWrAddr      <= '0;
      chanEnd        <= 1'b0;
      lenMismatchErr <= 1'b0;
    end else begin
      if (stb.markMismatch) lenMismatchErr <= 1'b1;
      if (stb.cfgLoad) begin
        chanCount <= cfgCount;
        dmaWrAddr <= cfgDstAddr;
        chanEnd   <= 1'b0;
      end else if (stb.popWord) begin
        chanCount <= chanCount - 1'b1;
        dmaWrAddr <= dmaWrAddr + STEP;
        if (chanCount == CNT_W'(1)) chanEnd <= 1'b1;
      end
    end
  end

  always_comb begin
    hostRdData = '0;
    case (hostSel)
      SEL_CTRL: begin
        hostRdData[CTRL_START_BIT]  = startFlag;
        hostRdData[CTRL_ROMVIS_BIT] = romVisible;
        hostRdData[CTRL_FULL_BIT]   = fifoFull;
      end
      SEL_LEN: hostRdData = DATA_W'(hostLen);
      default: hostRdData = '0;
    endcase
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushWord |-> (fillCnt < FULL_LEVEL))
    else $error("push into full FIFO"); // R10

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.popWord |-> (rdIdx < fillCnt))
    else $error("pop from empty FIFO"); // R4

  AST_END_ON_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.popWord && !stb.cfgLoad && chanCount == CNT_W'(1)) |=> chanEnd)
    else $error("transfer end not flagged"); // R7

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.popWord && !stb.ctrlWrite && hostLen == LEN_W'(1)) |=> !startFlag)
    else $error("start flag not dropped"); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lenMismatchErr |=> lenMismatchErr)
    else $error("mismatch error cleared"); // R9

endmodule

// File: rtl/dreq_fifo_bridge.sv
module dreq_fifo_bridge
  import dreq_bridge_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              startFlag,
  output logic              romVisible,
  output logic              fifoFull,
  output logic [LEN_W-1:0]  hostLen,
  output logic              anomaly,
  input  logic [1:0]        chanMode,
  input  logic              dmaGlobalEn,
  input  logic              cfgLoad,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  output logic              dmaReq,
  input  logic              dmaAck,
  output logic [ADDR_W-1:0] dmaWrAddr,
  output logic [DATA_W-1:0] dmaWrData,
  output logic [CNT_W-1:0]  chanCount,
  output logic              chanEnd,
  output logic              lenMismatchErr
);

  localparam int PTR_W = $clog2(DEPTH + 1);

  strobe_t          stb;
  logic [PTR_W-1:0] fillCnt, rdIdx;
  logic             chanCountZero, countLenDiffer;

  dreq_control #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .chanMode(chanMode), .dmaGlobalEn(dmaGlobalEn), .dmaAck(dmaAck),
    .cfgLoad(cfgLoad), .fillCnt(fillCnt), .rdIdx(rdIdx),
    .startFlag(startFlag), .fifoFull(fifoFull),
    .chanCountZero(chanCountZero), .countLenDiffer(countLenDiffer),
    .stb(stb), .dmaReq(dmaReq)
  );

  dreq_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .ADDR_W(ADDR_W), .ADDR_STEP(2), .PTR_W(PTR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostSel(hostSel),
    .hostWrData(hostWrData), .cfgCount(cfgCount), .cfgDstAddr(cfgDstAddr),
    .hostRdData(hostRdData), .fillCnt(fillCnt), .rdIdx(rdIdx),
    .startFlag(startFlag), .romVisible(romVisible), .fifoFull(fifoFull),
    .hostLen(hostLen), .anomaly(anomaly), .dmaWrAddr(dmaWrAddr),
    .dmaWrData(dmaWrData), .chanCount(chanCount),
    .chanCountZero(chanCountZero), .countLenDiffer(countLenDiffer),
    .chanEnd(chanEnd), .lenMismatchErr(lenMismatchErr)
  );

endmodule

// File: tb/tb_dreq_fifo_bridge.sv
module tb_dreq_fifo_bridge;
  localparam int DEPTH = 8;

  logic        clk = 0, rstN = 0;
  logic        hostWrEn = 0;
  logic [1:0]  hostSel = 0;
  logic [15:0] hostWrData = 0;
  logic [15:0] hostRdData;
  logic        startFlag, romVisible, fifoFull, anomaly;
  logic [15:0] hostLen;
  logic [1:0]  chanMode = 2'd1;
  logic        dmaGlobalEn = 0, cfgLoad = 0, dmaAck = 0;
  logic [23:0] cfgCount = 0;
  logic [31:0] cfgDstAddr = 0;
  logic        dmaReq, chanEnd, lenMismatchErr;
  logic [31:0] dmaWrAddr;
  logic [15:0] dmaWrData;
  logic [23:0] chanCount;

  int tests = 0, fails = 0, cycles = 0;

  dreq_fifo_bridge #(.DEPTH(DEPTH)) dut (.*);

  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  logic [15:0] q[$];
  int          mRd;
  bit          mDrain, mStart, mRom, mEnd, mErr, mAnom;
  logic [15:0] mLen;
  logic [23:0] mCount;
  logic [31:0] mDst;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mRd = 0; mDrain = 0; mStart = 0; mRom = 0; mEnd = 0;
      mErr = 0; mAnom = 0; mLen = 0; mCount = 0; mDst = 0;
    end else begin
      int  oSize;
      bit  oReq, grp, dataWr;
      oSize  = q.size();
      oReq   = mDrain && (mRd < oSize) && (mCount != 0);
      grp    = (oSize != 0) && (oSize % 4 == 0) && (chanMode == 2'd1) && dmaGlobalEn;
      dataWr = hostWrEn && (hostSel == 2'd2);
      mAnom  = dataWr && !mStart;
      if (mDrain) begin
        if (oReq && dmaAck) begin
          mRd++; mDst += 2;
          if (mCount == 1) mEnd = 1;
          mCount--;
          if (mLen == 1) mStart = 0;
          if (mLen != 0) mLen--;
        end else if (!oReq) begin
          q.delete(); mRd = 0; mDrain = 0;
        end
      end else if (grp) begin
        mDrain = 1;
        if (mCount != 24'(mLen)) mErr = 1;
      end else if (dataWr && mStart && oSize < DEPTH) begin
        q.push_back(hostWrData);
      end
      if (hostWrEn && hostSel == 2'd0) begin mStart = hostWrData[0]; mRom = hostWrData[1]; end
      if (hostWrEn && hostSel == 2'd1) mLen = hostWrData & 16'hFFFC;
      if (cfgLoad) begin mCount = cfgCount; mDst = cfgDstAddr; mEnd = 0; end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit eReq;
      logic [15:0] eRd;
      eReq = mDrain && (mRd < q.size()) && (mCount != 0);
      chk("R1/R4 hostLen", hostLen, mLen);
      chk("R2 anomaly", anomaly, mAnom);
      chk("R3 dmaReq", dmaReq, eReq);
      if (eReq) chk("R11 dmaWrData", dmaWrData, q[mRd]);
      chk("R4 dmaWrAddr", dmaWrAddr, mDst);
      chk("R4 chanCount", chanCount, mCount);
      chk("R5 fifoFull", fifoFull, q.size() == DEPTH);
      chk("R6 startFlag", startFlag, mStart);
      chk("R7 chanEnd", chanEnd, mEnd);
      chk("R8 romVisible", romVisible, mRom);
      chk("R9 lenMismatchErr", lenMismatchErr, mErr);
      case (hostSel)
        2'd0: eRd = {8'h00, (q.size() == DEPTH), 5'b0, mRom, mStart};
        2'd1: eRd = mLen;
        default: eRd = 16'h0;
      endcase
      chk("R8 hostRdData", hostRdData, eRd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hwrite(logic [1:0] sel, logic [15:0] d);
    hostWrEn = 1; hostSel = sel; hostWrData = d;
    step();
    hostWrEn = 0; hostSel = 2'd3;
  endtask

  task automatic cfg(logic [23:0] c, logic [31:0] a);
    cfgLoad = 1; cfgCount = c; cfgDstAddr = a;
    step();
    cfgLoad = 0;
  endtask

  task automatic pushWords(int n, logic [15:0] base);
    for (int i = 0; i < n; i++) hwrite(2'd2, base + 16'(i));
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    hostSel = 2'd3;
    step(3);
    rstN = 1;
    @(negedge clk);
    chk("R12 reset startFlag", startFlag, 0);
    chk("R12 reset hostLen", hostLen, 0);
    chk("R12 reset dmaReq", dmaReq, 0);
    chk("R12 reset chanCount", chanCount, 0);
    chk("R12 reset fifoFull", fifoFull, 0);
    step();

    hwrite(2'd1, 16'h0013);
    @(negedge clk); chk("R1 length masked", hostLen, 16'h0010);
    hwrite(2'd2, 16'hDEAD);
    @(negedge clk); chk("R2 anomaly pulse", anomaly, 1);
    step();
    @(negedge clk); chk("R2 anomaly single cycle", anomaly, 0);

    hwrite(2'd0, 16'hFFFF);
    hostSel = 2'd0;
    @(negedge clk); chk("R8 control readback", hostRdData, 16'h0003);
    hostSel = 2'd3;

    // first group, free-running acknowledge
    cfg(24'd16, 32'h0000_1000);
    dmaGlobalEn = 1; dmaAck = 1;
    pushWords(4, 16'hA100);
    step(8);
    @(negedge clk);
    chk("R4 count after group", chanCount, 24'd12);
    chk("R4 addr after group", dmaWrAddr, 32'h0000_1008);

    // unaligned fill stays quiet, then fill to full
    dmaGlobalEn = 0; dmaAck = 0;
    pushWords(5, 16'hB100);
    dmaGlobalEn = 1; step(3);
    @(negedge clk); chk("R3 no request at fill 5", dmaReq, 0);
    dmaGlobalEn = 0;
    pushWords(3, 16'hB105);
    @(negedge clk); chk("R5 full at depth", fifoFull, 1);
    hwrite(2'd2, 16'hBEEF);
    dmaGlobalEn = 1; step(3);
    @(negedge clk); chk("R3 request held without ack", dmaReq, 1);
    for (int i = 0; i < 10; i++) begin dmaAck = i[0]; step(); end
    dmaAck = 1; step(12);
    @(negedge clk);
    chk("R10 ninth word dropped", chanCount, 24'd4);
    chk("R5 full cleared after drain", fifoFull, 0);

    // wrong mode blocks, then completion of both counts
    chanMode = 2'd2;
    pushWords(4, 16'hC100);
    step(2);
    @(negedge clk); chk("R3 no request in mode 2", dmaReq, 0);
    chanMode = 2'd1; step(10);
    @(negedge clk);
    chk("R6 start cleared at zero length", startFlag, 0);
    chk("R7 end flagged at zero count", chanEnd, 1);

    // mismatch between count and length
    hwrite(2'd0, 16'h0001);
    hwrite(2'd1, 16'h0004);
    cfg(24'd8, 32'h0000_2000);
    @(negedge clk); chk("R7 end cleared by load", chanEnd, 0);
    pushWords(4, 16'hD100);
    step(10);
    @(negedge clk); chk("R9 mismatch flagged", lenMismatchErr, 1);

    // count runs out mid-burst
    hwrite(2'd0, 16'h0001);
    hwrite(2'd1, 16'h0008);
    cfg(24'd2, 32'h0000_3000);
    pushWords(4, 16'hE100);
    step(10);
    @(negedge clk);
    chk("R7 partial burst addr", dmaWrAddr, 32'h0000_3004);
    chk("R7 rest discarded", fifoFull, 0);
    pushWords(4, 16'hF100);
    step(6);
    @(negedge clk);
    chk("R7 no pops at zero count", hostLen, 16'h0006);
    chk("R9 error sticky", lenMismatchErr, 1);

    step(2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) cycles++;
endmodule